// File: doc/BRIEF.md
# Two-Word Coprocessor Load/Store Sequencer

This block sits between a 32-bit memory data path and a file of sixteen 64-bit coprocessor registers. Each register holds an upper and a lower 32-bit half. A memory transfer arrives as a sequence of beats. For each data beat the block either writes the incoming word into the addressed register (load) or presents one half of that register on the outgoing data bus (store).

The instruction word decides two things: whether the transfer carries two words or one, and which register is addressed. In a two-word transfer the endianness input sets which half goes with each beat. In a one-word transfer the format input sets the behaviour. Float words live in the upper half. Integer words live in the lower half, and an integer load also sign-extends into the upper half.

A handshake pair tells the memory side whether to fetch another word or to finish. A beat marked as a non-data phase returns the sequencer to its first beat. Address generation is done outside the block.

Top module: `cop_ldst_seq`

## Requirements
- R1: After reset every register reads as zero, and with no beat offered `st_data`, `beat_inc` and `beat_done` are all 0.
- R2: Instruction bit 22 set selects a two-word transfer and clear selects a one-word transfer. Bits 15..12 give the register index, and no other register is touched.
- R3: In a two-word transfer with `big_endian` low, the first beat uses the lower half and the second beat uses the upper half.
- R4: In a two-word transfer with `big_endian` high, the first beat uses the upper half and the second beat uses the lower half.
- R5: In the same cycle as a beat, a first beat of a two-word transfer raises `beat_inc` only. The second beat, and every one-word beat, raise `beat_done` only.
- R6: A beat with `data_phase` low raises `beat_done` only, writes nothing, and makes the next two-word data beat a first beat again.
- R7: A one-word beat with `fmt_float` high loads into the upper half and leaves the lower half unchanged. A store of this kind returns the upper half.
- R8: A one-word integer load (`fmt_float` low) writes the word into the lower half and fills the upper half with copies of bit 31.
- R9: A one-word integer store returns the lower half.
- R10: Store beats and cycles with `xfer_valid` low change no register. With `xfer_valid` low, `st_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset that clears registers and the beat counter |
| xfer_valid | input | 1 | A beat is offered this cycle |
| data_phase | input | 1 | 1 = data beat, 0 = non-data phase |
| is_store | input | 1 | 1 = store (register to memory), 0 = load |
| instr | input | 32 | Instruction word: bit 22 selects long transfer, bits 15..12 give the register index |
| fmt_float | input | 1 | One-word format: 1 = float (upper half), 0 = integer |
| big_endian | input | 1 | Beat order for two-word transfers |
| ld_data | input | 32 | Word arriving from memory |
| st_data | output | 32 | Word sent to memory on a store beat, 0 otherwise |
| beat_inc | output | 1 | Request one more word |
| beat_done | output | 1 | Transfer complete |

## Verification
The assertions assume that `instr`, `is_store`, `fmt_float` and `big_endian` stay constant across the two beats of a long transfer. They also assume that a long transfer is closed by its second beat or by a non-data phase before a new one starts. The directed tasks drive every multi-beat sequence with fixed instruction fields and finish it before the next scenario begins. The tasks mix in idle cycles only between beats, never as a change of instruction. All inputs change at the falling edge, so each beat is seen for exactly one rising edge.

// File: rtl/cop_ldst_pkg.sv
package cop_ldst_pkg;
  localparam int WORD_W = 32;
  typedef logic [WORD_W-1:0] word_t;

  // Which half a beat uses: long transfers alternate by beat and endianness,
  // single words go to the upper half only for float format.
  function automatic logic lane_is_upper(input logic long_x, input logic second,
                                         input logic be, input logic flt);
    if (long_x) return be ^ second;
    return flt;
  endfunction

  function automatic word_t sign_fill(input word_t w);
    return {WORD_W{w[WORD_W-1]}};
  endfunction
endpackage

// File: rtl/cop_beat_ctr.sv
module cop_beat_ctr (
  input  logic clk,
  input  logic rst_n,
  input  logic valid,
  input  logic phase,
  input  logic long_x,
  output logic second,
  output logic inc,
  output logic done
);
  logic cnt_q;

  assign second = cnt_q;
  assign inc    = valid & phase & long_x & ~cnt_q;
  assign done   = valid & (~phase | ~long_x | cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= 1'b0;
    else if (valid) cnt_q <= phase & long_x & ~cnt_q;
  end
endmodule

// File: rtl/cop_half_regfile.sv
module cop_half_regfile
  import cop_ldst_pkg::*;
#(
  parameter int NREGS = 16,
  localparam int IDXW = $clog2(NREGS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [IDXW-1:0] idx,
  input  logic            wr_hi,
  input  logic            wr_lo,
  input  word_t           hi_din,
  input  word_t           lo_din,
  output word_t           hi_dout,
  output word_t           lo_dout
);
  word_t hi_q [NREGS];
  word_t lo_q [NREGS];

  for (genvar g = 0; g < NREGS; g++) begin : g_entry
    logic hit;
    assign hit = (idx == IDXW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hi_q[g] <= '0;
        lo_q[g] <= '0;
      end else begin
        if (hit && wr_hi) hi_q[g] <= hi_din;
        if (hit && wr_lo) lo_q[g] <= lo_din;
      end
    end
  end

  assign hi_dout = hi_q[idx];
  assign lo_dout = lo_q[idx];
endmodule

// File: rtl/cop_ldst_seq.sv
module cop_ldst_seq
  import cop_ldst_pkg::*;
#(
  parameter int NREGS    = 16,
  parameter int LONG_BIT = 22,
  parameter int IDX_LSB  = 12,
  localparam int IDXW    = $clog2(NREGS)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        xfer_valid,
  input  logic        data_phase,
  input  logic        is_store,
  input  logic [31:0] instr,
  input  logic        fmt_float,
  input  logic        big_endian,
  input  logic [31:0] ld_data,
  output logic [31:0] st_data,
  output logic        beat_inc,
  output logic        beat_done
);
  logic            long_x, second, upper_sel, beat_live, ld_live, int_single;
  logic            wr_hi, wr_lo;
  logic [IDXW-1:0] idx;
  word_t           hi_din, rd_hi, rd_lo;
  logic            unused_instr;

  assign long_x       = instr[LONG_BIT];
  assign idx          = instr[IDX_LSB +: IDXW];
  assign unused_instr = ^instr;

  cop_beat_ctr u_ctr (
    .clk(clk), .rst_n(rst_n), .valid(xfer_valid), .phase(data_phase),
    .long_x(long_x), .second(second), .inc(beat_inc), .done(beat_done)
  );

  assign upper_sel  = lane_is_upper(long_x, second, big_endian, fmt_float);
  assign beat_live  = xfer_valid & data_phase;
  assign ld_live    = beat_live & ~is_store;
  assign int_single = ~long_x & ~fmt_float;

  assign wr_hi  = ld_live & (upper_sel | int_single);
  assign wr_lo  = ld_live & ~upper_sel;
  assign hi_din = int_single ? sign_fill(ld_data) : ld_data;

  cop_half_regfile #(.NREGS(NREGS)) u_rf (
    .clk(clk), .rst_n(rst_n), .idx(idx), .wr_hi(wr_hi), .wr_lo(wr_lo),
    .hi_din(hi_din), .lo_din(ld_data), .hi_dout(rd_hi), .lo_dout(rd_lo)
  );

  assign st_data = (beat_live & is_store) ? (upper_sel ? rd_hi : rd_lo) : '0;

  AST_ONE_HANDSHAKE: assert property (@(posedge clk) disable iff (!rst_n) !(beat_inc && beat_done)); // R5
  AST_SECOND_FINISHES: assert property (@(posedge clk) disable iff (!rst_n) $past(beat_inc) && beat_live && long_x |-> beat_done); // R5
  AST_NONDATA_DONE: assert property (@(posedge clk) disable iff (!rst_n) xfer_valid && !data_phase |-> beat_done && !wr_hi && !wr_lo); // R6
  AST_RESTART_FIRST: assert property (@(posedge clk) disable iff (!rst_n) $past(xfer_valid && !data_phase) && beat_live && long_x |-> beat_inc); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !xfer_valid |-> !beat_inc && !beat_done && st_data == '0 && !wr_hi && !wr_lo); // R10
  AST_STORE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n) is_store |-> !wr_hi && !wr_lo); // R10
  AST_BOTH_HALVES_SEXT: assert property (@(posedge clk) disable iff (!rst_n) wr_hi && wr_lo |-> hi_din == {32{ld_data[31]}}); // R8
endmodule

// File: tb/cop_ldst_seq_bench.sv
module cop_ldst_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        xfer_valid = 1'b0, data_phase = 1'b0, is_store = 1'b0;
  logic [31:0] instr = '0;
  logic        fmt_float = 1'b0, big_endian = 1'b0;
  logic [31:0] ld_data = '0;
  logic [31:0] st_data;
  logic        beat_inc, beat_done;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [31:0] m_hi [16];
  logic [31:0] m_lo [16];

  always #5 clk = ~clk;

  cop_ldst_seq u_cop_ldst_seq (
    .clk(clk), .rst_n(rst_n), .xfer_valid(xfer_valid), .data_phase(data_phase),
    .is_store(is_store), .instr(instr), .fmt_float(fmt_float),
    .big_endian(big_endian), .ld_data(ld_data), .st_data(st_data),
    .beat_inc(beat_inc), .beat_done(beat_done)
  );

  function automatic logic [31:0] mk(input logic lng, input logic [3:0] r);
    return (32'(lng) << 22) | (32'(r) << 12);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One beat: drive at falling edge, sample before the next rising edge.
  task automatic beat(input logic ph, input logic st, input logic lng, input logic [3:0] r,
                      input logic flt, input logic be, input logic [31:0] d,
                      output logic [31:0] so, output logic inc, output logic dn);
    @(negedge clk);
    xfer_valid = 1'b1; data_phase = ph; is_store = st; instr = mk(lng, r);
    fmt_float = flt; big_endian = be; ld_data = d;
    #1;
    so = st_data; inc = beat_inc; dn = beat_done;
  endtask

  task automatic idle();
    @(negedge clk);
    xfer_valid = 1'b0; data_phase = 1'b0; is_store = 1'b0; ld_data = '0;
  endtask

  // Read a register as {hi, lo} with a little-endian long store.
  task automatic read64(input logic [3:0] r, output logic [31:0] hi, output logic [31:0] lo);
    logic i, d;
    beat(1, 1, 1, r, 0, 0, 32'h0, lo, i, d);
    beat(1, 1, 1, r, 0, 0, 32'h0, hi, i, d);
    idle();
  endtask

  task automatic expect_reg(input string req, input logic [3:0] r);
    logic [31:0] h, l;
    read64(r, h, l);
    chk({req, " hi"}, h, m_hi[r]);
    chk({req, " lo"}, l, m_lo[r]);
  endtask

  task automatic t_reset();
    #1;
    chk("R1 idle st_data", st_data, 32'h0);
    chk("R1 idle inc", 32'(beat_inc), 0);
    chk("R1 idle done", 32'(beat_done), 0);
    expect_reg("R1 r0", 4'd0);
    expect_reg("R1 r15", 4'd15);
  endtask

  task automatic t_long_le();
    logic [31:0] so; logic i, d;
    beat(1, 0, 1, 4'd3, 0, 0, 32'hAAAA_0001, so, i, d);
    chk("R5 first beat inc", 32'(i), 1);
    chk("R5 first beat done", 32'(d), 0);
    beat(1, 0, 1, 4'd3, 0, 0, 32'hBBBB_0002, so, i, d);
    chk("R5 second beat inc", 32'(i), 0);
    chk("R5 second beat done", 32'(d), 1);
    idle();
    m_lo[3] = 32'hAAAA_0001; m_hi[3] = 32'hBBBB_0002;
    expect_reg("R3 le load", 4'd3);
    // big-endian store: upper first
    beat(1, 1, 1, 4'd3, 0, 1, 32'h0, so, i, d);
    chk("R4 be store beat1", so, 32'hBBBB_0002);
    beat(1, 1, 1, 4'd3, 0, 1, 32'h0, so, i, d);
    chk("R4 be store beat2", so, 32'hAAAA_0001);
    idle();
  endtask

  task automatic t_long_be();
    logic [31:0] so; logic i, d;
    beat(1, 0, 1, 4'd7, 0, 1, 32'hC0C0_C0C0, so, i, d);
    beat(1, 0, 1, 4'd7, 0, 1, 32'hD1D1_D1D1, so, i, d);
    idle();
    m_hi[7] = 32'hC0C0_C0C0; m_lo[7] = 32'hD1D1_D1D1;
    expect_reg("R4 be load", 4'd7);
  endtask

  task automatic t_index();
    logic [31:0] so; logic i, d;
    beat(1, 0, 1, 4'd15, 0, 0, 32'h1515_0000, so, i, d);
    beat(1, 0, 1, 4'd15, 0, 0, 32'h1515_FFFF, so, i, d);
    idle();
    m_lo[15] = 32'h1515_0000; m_hi[15] = 32'h1515_FFFF;
    expect_reg("R2 target r15", 4'd15);
    expect_reg("R2 neighbour r14", 4'd14);
  endtask

  task automatic t_float();
    logic [31:0] so; logic i, d;
    beat(1, 0, 0, 4'd3, 1, 0, 32'h3F80_0000, so, i, d);
    chk("R5 single done", 32'(d), 1);
    chk("R5 single inc", 32'(i), 0);
    idle();
    m_hi[3] = 32'h3F80_0000;
    expect_reg("R7 float load", 4'd3);
    beat(1, 1, 0, 4'd3, 1, 1, 32'h0, so, i, d);
    chk("R7 float store", so, 32'h3F80_0000);
    idle();
  endtask

  task automatic t_int();
    logic [31:0] so; logic i, d;
    beat(1, 0, 0, 4'd9, 0, 1, 32'h8000_0001, so, i, d);
    idle();
    m_hi[9] = 32'hFFFF_FFFF; m_lo[9] = 32'h8000_0001;
    expect_reg("R8 negative sext", 4'd9);
    beat(1, 0, 0, 4'd7, 0, 0, 32'h0000_0007, so, i, d);
    idle();
    m_hi[7] = 32'h0; m_lo[7] = 32'h0000_0007;
    expect_reg("R8 positive sext", 4'd7);
    beat(1, 1, 0, 4'd9, 0, 1, 32'h0, so, i, d);
    chk("R9 int store lower", so, 32'h8000_0001);
    idle();
  endtask

  task automatic t_nondata();
    logic [31:0] so; logic i, d;
    beat(1, 0, 1, 4'd4, 0, 0, 32'h4444_1111, so, i, d);
    chk("R6 pre inc", 32'(i), 1);
    beat(0, 0, 1, 4'd4, 0, 0, 32'hDEAD_BEEF, so, i, d);
    chk("R6 nondata done", 32'(d), 1);
    chk("R6 nondata inc", 32'(i), 0);
    beat(1, 0, 1, 4'd4, 0, 0, 32'h4444_2222, so, i, d);
    chk("R6 restart inc", 32'(i), 1);
    beat(1, 0, 1, 4'd4, 0, 0, 32'h4444_3333, so, i, d);
    chk("R6 restart done", 32'(d), 1);
    idle();
    m_lo[4] = 32'h4444_2222; m_hi[4] = 32'h4444_3333;
    expect_reg("R6 restart halves", 4'd4);
  endtask

  task automatic t_idle();
    logic [31:0] so; logic i, d;
    @(negedge clk);
    xfer_valid = 1'b0; data_phase = 1'b1; is_store = 1'b0; instr = mk(0, 4'd4);
    fmt_float = 1'b0; ld_data = 32'h9999_9999;
    #1;
    chk("R10 idle st_data", st_data, 32'h0);
    chk("R10 idle done", 32'(beat_done), 0);
    @(negedge clk);
    idle();
    expect_reg("R10 idle no write", 4'd4);
    beat(1, 1, 0, 4'd4, 0, 0, 32'h5555_5555, so, i, d);
    idle();
    expect_reg("R10 store no write", 4'd4);
  endtask

  initial begin
    for (int k = 0; k < 16; k++) begin m_hi[k] = '0; m_lo[k] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_long_le();
    t_long_be();
    t_index();
    t_float();
    t_int();
    t_nondata();
    t_idle();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule